// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage Pipeline

This block decides when a five-stage in-order pipeline leaves its normal instruction stream for a handler. Four stages can flag a fault against an instruction: fetch can flag a bad PC address, decode an illegal opcode, execute an arithmetic overflow, and memory a bad data address. The flag does not act where it is raised. It travels with the instruction's PC and valid bit through the decode, execute and memory stage registers. The memory stage is the single commit point, and the trap decision is made there.

At the commit point, an asynchronous interrupt that is enabled takes precedence over any fault. When the block takes a trap, it does the following in the same cycle. It records a cause code and the PC of the instruction that did not complete. It kills every younger instruction and blocks the writeback of the victim. It steers fetch to a fixed handler address and turns off interrupts. Every older instruction has already retired at that point, so the trap is precise. A return-from-trap strobe turns interrupts back on.

Top module: `precise_trap_unit`

## Requirements
- R1: After reset the cause register reads 0, the trap PC register reads 0, interrupts are disabled, and neither redirect nor retire is asserted.
- R2: A faulting instruction that reaches the commit point traps in that cycle. The cause codes are 1 for a fetch address fault, 2 for an illegal opcode, 3 for overflow and 4 for a data address fault. On the next cycle the trap PC register holds that instruction's PC.
- R3: When one instruction is flagged in more than one stage, the cause recorded is the flag from the earliest stage (fetch before decode, decode before execute, execute before memory).
- R4: An interrupt request seen while interrupts are enabled and a valid instruction sits at the commit point traps with cause 0. This takes precedence over any fault of that instruction, and the trap PC is that instruction's PC.
- R5: While interrupts are disabled, the interrupt request has no effect: instructions retire normally.
- R6: In a trap cycle, redirect, squash and writeback-kill are all high, handlerPc carries the handler address (default 32'h0000_0080), and retire is low.
- R7: Every instruction younger than the trapping one is discarded. These are the instructions then in execute and decode, plus the one being fetched. None of them ever retires or traps.
- R8: A trap clears the interrupt enable. A return-from-trap strobe sets it in the next cycle, except when a trap occurs in the same cycle, in which case the trap wins and the enable stays clear.
- R9: While hold is high, the stage registers keep their contents, and neither a trap nor a retirement occurs. A fault held at the commit point traps once hold falls.
- R10: A bubble (fetch valid low) never retires and never traps. A pending interrupt waits until a valid instruction reaches the commit point.
- R11: Instructions older than a trapping one retire in program order before the trap, each with its own PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| holdIn | input | 1 | Pipeline stall, freezes all stage registers |
| fetchValid | input | 1 | Fetch stage holds a real instruction |
| fetchPc | input | PCW | PC of the fetched instruction |
| fetchFault | input | 1 | PC address fault for the fetched instruction |
| decIllegal | input | 1 | Illegal opcode for the instruction in decode |
| exeOverflow | input | 1 | Overflow for the instruction in execute |
| memFault | input | 1 | Data address fault for the instruction in memory |
| irqIn | input | 1 | Asynchronous interrupt request (level) |
| rfeIn | input | 1 | Return-from-trap strobe |
| redirect | output | 1 | Trap taken this cycle; fetch must load handlerPc |
| handlerPc | output | PCW | Handler entry address |
| squash | output | 1 | Kill the fetch, decode and execute stages |
| wbKill | output | 1 | Suppress writeback of the commit-point instruction |
| retireValid | output | 1 | Commit-point instruction completes this cycle |
| retirePc | output | PCW | PC of the commit-point instruction |
| causeReg | output | 3 | Cause of the last trap |
| epcReg | output | PCW | PC of the instruction that did not complete |
| intEnable | output | 1 | Interrupt enable |

## Verification
A flag that is lost or misrouted inside the stage registers shows up three cycles after the faulting fetch. At that point the instruction either retires when it should have trapped, or it traps with the wrong cause one cycle before the cause register is read. An incomplete flush becomes visible in the cycle after the trap, when a younger instruction appears as a retirement that the scoreboard never expected. A wrong interrupt-enable state shows up in the very next cycle: an interrupt is taken that should have been ignored, or one is ignored that should have been taken.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // Trap cause encodings; C_NONE marks "no fault carried"
  typedef enum logic [2:0] {
    C_IRQ   = 3'd0,
    C_FETCH = 3'd1,
    C_ILL   = 3'd2,
    C_OVF   = 3'd3,
    C_DADDR = 3'd4,
    C_NONE  = 3'd7
  } causeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // stage registers load
    logic flush;    // trap taken: clear stages, write cause/EPC
    logic useIrq;   // trap source is the interrupt
    logic setIe;    // return-from-trap
    logic retire;   // commit-point instruction completes
  } strobeT;

  localparam int NUM_STG = 3;  // decode, execute, memory registers

endpackage

// File: rtl/trap_path.sv
module trap_path
  import trap_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobeT         st,
  input  logic           fetchValid,
  input  logic [PCW-1:0] fetchPc,
  input  logic           fetchFault,
  input  logic [NUM_STG-1:0] raiseIn,  // [0] decode, [1] execute, [2] memory
  output logic           mValid,
  output logic [PCW-1:0] mPc,
  output causeT          mCode,
  output logic [2:0]     causeReg,
  output logic [PCW-1:0] epcReg,
  output logic           intEnable
);

  logic [NUM_STG-1:0] stValid;
  logic [PCW-1:0]     stPc   [NUM_STG];
  causeT              stCode [NUM_STG];
  causeT              mergedCode [NUM_STG];

  logic [NUM_STG-1:0] inValid;
  logic [PCW-1:0]     inPc   [NUM_STG];
  causeT              inCode [NUM_STG];

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stage
    // An already-carried (older-stage) flag wins over one raised here
    assign mergedCode[s] = (stCode[s] != C_NONE) ? stCode[s] :
                           (stValid[s] && raiseIn[s]) ? causeT'(3'(s + 2)) : C_NONE;
    if (s == 0) begin : g_first
      assign inValid[s] = fetchValid;
      assign inPc[s]    = fetchPc;
      assign inCode[s]  = (fetchValid && fetchFault) ? C_FETCH : C_NONE;
    end else begin : g_next
      assign inValid[s] = stValid[s-1];
      assign inPc[s]    = stPc[s-1];
      assign inCode[s]  = mergedCode[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.flush) begin
      stValid <= '0;
      for (int s = 0; s < NUM_STG; s++) begin
        stPc[s]   <= '0;
        stCode[s] <= C_NONE;
      end
    end else if (st.advance) begin
      stValid <= inValid;
      for (int s = 0; s < NUM_STG; s++) begin
        stPc[s]   <= inPc[s];
        stCode[s] <= inCode[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeReg  <= 3'(C_IRQ);
      epcReg    <= '0;
      intEnable <= 1'b0;
    end else if (st.flush) begin
      causeReg  <= st.useIrq ? 3'(C_IRQ) : 3'(mergedCode[NUM_STG-1]);
      epcReg    <= stPc[NUM_STG-1];
      intEnable <= 1'b0;
    end else if (st.setIe) begin
      intEnable <= 1'b1;
    end
  end

  assign mValid = stValid[NUM_STG-1];
  assign mPc    = stPc[NUM_STG-1];
  assign mCode  = mergedCode[NUM_STG-1];

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic   holdIn,
  input  logic   irqIn,
  input  logic   rfeIn,
  input  logic   mValid,
  input  causeT  mCode,
  input  logic   intEnable,
  output strobeT st
);

  logic irqLive;
  logic take;

  assign irqLive = irqIn && intEnable;
  assign take    = !holdIn && mValid && (irqLive || (mCode != C_NONE));

  always_comb begin
    st.advance = !holdIn;
    st.flush   = take;
    st.useIrq  = irqLive;
    st.setIe   = rfeIn;
    st.retire  = !holdIn && mValid && !take;
  end

endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
  import trap_pkg::*;
#(
  parameter int              PCW        = 32,
  parameter logic [PCW-1:0]  HANDLER_PC = 32'h0000_0080
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           holdIn,
  input  logic           fetchValid,
  input  logic [PCW-1:0] fetchPc,
  input  logic           fetchFault,
  input  logic           decIllegal,
  input  logic           exeOverflow,
  input  logic           memFault,
  input  logic           irqIn,
  input  logic           rfeIn,
  output logic           redirect,
  output logic [PCW-1:0] handlerPc,
  output logic           squash,
  output logic           wbKill,
  output logic           retireValid,
  output logic [PCW-1:0] retirePc,
  output logic [2:0]     causeReg,
  output logic [PCW-1:0] epcReg,
  output logic           intEnable
);

  strobeT st;
  logic   mValid;
  causeT  mCode;

  trap_ctrl i_ctrl (
    .holdIn    (holdIn),
    .irqIn     (irqIn),
    .rfeIn     (rfeIn),
    .mValid    (mValid),
    .mCode     (mCode),
    .intEnable (intEnable),
    .st        (st)
  );

  trap_path #(.PCW(PCW)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .fetchFault (fetchFault),
    .raiseIn    ({memFault, exeOverflow, decIllegal}),
    .mValid     (mValid),
    .mPc        (retirePc),
    .mCode      (mCode),
    .causeReg   (causeReg),
    .epcReg     (epcReg),
    .intEnable  (intEnable)
  );

  assign redirect    = st.flush;
  assign squash      = st.flush;
  assign wbKill      = st.flush;
  assign retireValid = st.retire;
  assign handlerPc   = HANDLER_PC;

endmodule

// File: rtl/precise_trap_unit_chk.sv
module precise_trap_unit_chk #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           holdIn,
  input logic           irqIn,
  input logic           rfeIn,
  input logic           redirect,
  input logic           squash,
  input logic           wbKill,
  input logic           retireValid,
  input logic [PCW-1:0] retirePc,
  input logic [2:0]     causeReg,
  input logic [PCW-1:0] epcReg,
  input logic           intEnable
);

  p_kill_together_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (squash && wbKill && !retireValid));

  p_epc_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (epcReg == $past(retirePc)));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && irqIn && intEnable) |=> (causeReg == 3'd0));

  p_masked_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !intEnable) |=> (causeReg != 3'd0));

  p_take_clears_ie_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !intEnable);

  p_rfe_sets_ie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rfeIn && !redirect) |=> intEnable);

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    holdIn |-> (!redirect && !retireValid));

  p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    holdIn |=> ($stable(causeReg) && $stable(epcReg)));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (!retireValid && !redirect));

endmodule

bind precise_trap_unit precise_trap_unit_chk #(.PCW(PCW)) i_chk (.*);

// File: tb/test_precise_trap_unit.sv
module test_precise_trap_unit;

  localparam int PCW = 32;
  localparam logic [PCW-1:0] HANDLER = 32'h0000_0080;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           holdIn = 1'b0;
  logic           fetchValid = 1'b0;
  logic [PCW-1:0] fetchPc = '0;
  logic           fetchFault = 1'b0;
  logic           decIllegal = 1'b0;
  logic           exeOverflow = 1'b0;
  logic           memFault = 1'b0;
  logic           irqIn = 1'b0;
  logic           rfeIn = 1'b0;
  logic           redirect, squash, wbKill, retireValid, intEnable;
  logic [PCW-1:0] handlerPc, retirePc, epcReg;
  logic [2:0]     causeReg;

  always #2 clk = ~clk;  // 250 MHz

  precise_trap_unit #(.PCW(PCW), .HANDLER_PC(HANDLER)) i_precise_trap_unit (.*);

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input logic [PCW-1:0] act,
                       input logic [PCW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    bit             isTrap;
    logic [PCW-1:0] pc;
    logic [2:0]     cause;
    string          req;
  } evT;
  evT expQ[$];

  task automatic pushRetire(input logic [PCW-1:0] pc, input string req);
    evT e; e.isTrap = 0; e.pc = pc; e.cause = 0; e.req = req; expQ.push_back(e);
  endtask
  task automatic pushTrap(input logic [PCW-1:0] pc, input logic [2:0] c, input string req);
    evT e; e.isTrap = 1; e.pc = pc; e.cause = c; e.req = req; expQ.push_back(e);
  endtask

  bit             monOn = 0;
  bit             pendTrap = 0;
  evT             pendEv;

  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (pendTrap) begin
        pendTrap = 0;
        check(causeReg == pendEv.cause, {pendEv.req, " cause"}, causeReg, pendEv.cause);
        check(epcReg == pendEv.pc, {pendEv.req, " trap pc"}, epcReg, pendEv.pc);
      end
      if (retireValid || redirect) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected event", retirePc, '0);
        end else begin
          evT e;
          e = expQ.pop_front();
          if (e.isTrap) begin
            check(redirect, {e.req, " trap taken"}, retirePc, e.pc);
            if (redirect) begin
              check(squash && wbKill && !retireValid, "R6 kill strobes",
                    {squash, wbKill, retireValid}, 3'b110);
              check(handlerPc == HANDLER, "R6 handler pc", handlerPc, HANDLER);
              pendTrap = 1;
              pendEv = e;
            end
          end else begin
            check(retireValid && retirePc == e.pc, {e.req, " retire"}, retirePc, e.pc);
          end
        end
      end
    end
  end

  // Program description for the driver
  logic [PCW-1:0] pPc [16];
  bit pFf [16], pIll [16], pOvf [16], pMf [16];

  task automatic setIns(input int i, input logic [PCW-1:0] pc, input bit ff, input bit il,
                        input bit ov, input bit mf);
    pPc[i] = pc; pFf[i] = ff; pIll[i] = il; pOvf[i] = ov; pMf[i] = mf;
  endtask

  // Expected outcome from the requirements: earliest-stage flag wins (R3),
  // older ones retire (R11), younger ones vanish (R7).
  task automatic expectProg(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [2:0] c;
      bit f;
      f = 1;
      if (pFf[i]) c = 3'd1;
      else if (pIll[i]) c = 3'd2;
      else if (pOvf[i]) c = 3'd3;
      else if (pMf[i]) c = 3'd4;
      else f = 0;
      if (f) begin
        pushTrap(pPc[i], c, req);
        break;
      end
      pushRetire(pPc[i], "R11");
    end
  endtask

  // Back-to-back fetch; stage flags follow the fetch slot by 1/2/3 cycles
  task automatic runProg(input int n, input int rfeCyc);
    for (int c = 0; c < n + 6; c++) begin
      @(posedge clk); #1;
      fetchValid  = (c < n);
      fetchPc     = (c < n) ? pPc[c] : '0;
      fetchFault  = (c < n) ? pFf[c] : 1'b0;
      decIllegal  = (c >= 1 && c - 1 < n) ? pIll[c-1] : 1'b0;
      exeOverflow = (c >= 2 && c - 2 < n) ? pOvf[c-2] : 1'b0;
      memFault    = (c >= 3 && c - 3 < n) ? pMf[c-3] : 1'b0;
      rfeIn       = (c == rfeCyc);
    end
    @(posedge clk); #1;
    fetchValid = 0; fetchFault = 0; decIllegal = 0; exeOverflow = 0; memFault = 0; rfeIn = 0;
  endtask

  task automatic pulseRfe();
    @(posedge clk); #1; rfeIn = 1;
    @(posedge clk); #1; rfeIn = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(causeReg == 0, "R1 cause", causeReg, 0);
    check(epcReg == 0, "R1 epc", epcReg, 0);
    check(!intEnable, "R1 ie", intEnable, 0);
    check(!redirect && !retireValid, "R1 quiet", {redirect, retireValid}, 0);
    monOn = 1;

    // Clean stream
    for (int i = 0; i < 4; i++) setIns(i, 32'h100 + 4 * i, 0, 0, 0, 0);
    expectProg(4, "R11");
    runProg(4, -1);

    // Simultaneous faults in E (illegal), D (fetch fault) while overflow commits
    for (int i = 0; i < 6; i++) setIns(i, 32'h200 + 4 * i, 0, 0, 0, 0);
    pOvf[2] = 1; pIll[3] = 1; pFf[4] = 1; pMf[5] = 1;
    expectProg(6, "R2 R7 overflow");
    runProg(6, -1);

    // Same-instruction priority
    setIns(0, 32'h300, 1, 1, 1, 1);
    expectProg(1, "R3 fetch first");
    runProg(1, -1);
    setIns(0, 32'h304, 0, 1, 0, 1);
    expectProg(1, "R3 illegal over data");
    runProg(1, -1);
    setIns(0, 32'h308, 0, 0, 1, 1);
    expectProg(1, "R3 overflow over data");
    runProg(1, -1);
    setIns(0, 32'h30c, 0, 0, 0, 1);
    setIns(1, 32'h310, 0, 0, 0, 0);
    expectProg(2, "R2 data fault");
    runProg(2, -1);

    // Return-from-trap
    pulseRfe();
    @(negedge clk);
    check(intEnable, "R8 rfe sets ie", intEnable, 1);

    // Enabled interrupt overrides overflow
    irqIn = 1;
    setIns(0, 32'h400, 0, 0, 1, 0);
    setIns(1, 32'h404, 0, 0, 0, 0);
    pushTrap(32'h400, 3'd0, "R4 irq");
    runProg(2, -1);
    @(negedge clk);
    check(!intEnable, "R8 trap clears ie", intEnable, 0);

    // Masked interrupt: normal retirement
    for (int i = 0; i < 3; i++) setIns(i, 32'h420 + 4 * i, 0, 0, 0, 0);
    expectProg(3, "R5");
    for (int i = 0; i < 3; i++) expQ[i].req = "R5 masked irq";
    runProg(3, -1);
    irqIn = 0;

    // Trap beats return-from-trap in the same cycle
    setIns(0, 32'h440, 0, 0, 0, 1);
    expectProg(1, "R8 same-cycle");
    runProg(1, 3);
    @(negedge clk);
    check(!intEnable, "R8 trap wins over rfe", intEnable, 0);

    // Pending interrupt with only bubbles in flight
    pulseRfe();
    irqIn = 1;
    begin
      int seen = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (redirect || retireValid) seen++;
      end
      check(seen == 0, "R10 bubbles silent", seen, 0);
    end
    irqIn = 0;
    @(negedge clk);
    check(intEnable, "R10 ie kept", intEnable, 1);

    // Hold at the commit point
    pushTrap(32'h500, 3'd3, "R9 after hold");
    @(posedge clk); #1; fetchValid = 1; fetchPc = 32'h500;
    @(posedge clk); #1; fetchValid = 0; fetchPc = 0;
    @(posedge clk); #1; exeOverflow = 1;
    @(posedge clk); #1; exeOverflow = 0; holdIn = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!redirect && !retireValid, "R9 held", {redirect, retireValid}, 0);
      @(posedge clk); #1;
    end
    holdIn = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule